// File: doc/BRIEF.md
# Alerting Tone Qualification Sequencer

This block is the decision stage behind a dual-frequency alerting-tone detector. Upstream peak and envelope logic supplies three single-bit qualifiers: a flag that a tone-like signal is present, a flag that the candidate already passed the spectral checks, and a strobe that the input gain has just been changed. The sequencer turns these into one verdict per candidate tone. It emits either a one-cycle accept pulse or a one-cycle reject pulse, and then returns to idle.

A candidate starts only on a rising edge of the tone-like flag. A fixed observation window follows, after which the spectral-pass flag is sampled. If that flag is present, a length phase measures how long it stays high until the tone-like flag drops. A real alerting tone has a fixed length of roughly 75 to 85 ms, so a pass flag that persists too long marks a false tone such as speech. A gain change while a candidate is open abandons it without any verdict.

All timing comes from a prescaler that yields a half-millisecond tick from the system clock. The defaults assume a 3.579545 MHz clock, a 58 ms window and a 22.5 ms limit on the pass-flag duration.

Top module: `alert_tone_qualifier`

## Requirements
- R1: A synchronous active-high `rst` returns the sequencer to idle and clears every counter. Both outputs are low in the cycle after reset. A tone-like flag that is already high when reset ends does not open a candidate.
- R2: A candidate opens only when `tone_seen` rises. A low `tone_seen`, or a level held high, opens nothing. `pre_hit` and `gain_step` have no effect while idle.
- R3: The observation window lasts `WINDOW_TICKS` half-ms ticks, one tick every `HALF_MS_DIV` clocks. No verdict issues from a window that is still running unless `tone_seen` drops (R5) or the gain steps (R8).
- R4: If `pre_hit` is low in the cycle the window expires, `alert_bad` pulses in the next cycle.
- R5: If `tone_seen` falls during the observation window, `alert_bad` pulses in the cycle after `tone_seen` is first seen low.
- R6: If `pre_hit` is high at window expiry, a length phase counts the ticks on which `pre_hit` is high. When `tone_seen` is first seen low, `alert_ok` pulses in the next cycle if that count is below `LEN_LIMIT_TICKS`.
- R7: In the length phase, a count that has reached `LEN_LIMIT_TICKS` when `tone_seen` is first seen low gives an `alert_bad` pulse instead.
- R8: `gain_step` high in either phase returns the sequencer to idle with no pulse. A fresh rise of `tone_seen` is then needed to open a new candidate.
- R9: `alert_ok` and `alert_bad` are never high together, and each pulse lasts exactly one cycle.
- R10: Each phase restarts the prescaler. Its first tick falls `HALF_MS_DIV` clocks after the phase is entered, so the tick count that decides R6 against R7 flips exactly at a multiple of `HALF_MS_DIV` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tone_seen | input | 1 | Tone-like signal present (from peak analysis) |
| pre_hit | input | 1 | Candidate passed the spectral checks |
| gain_step | input | 1 | Gain was changed in this cycle |
| alert_ok | output | 1 | One-cycle pulse: tone accepted |
| alert_bad | output | 1 | One-cycle pulse: tone rejected |

## Verification
The sequencer is tried with the following input patterns:
- A short tone that ends inside the window.
- A tone whose pass flag never appears.
- Tones whose pass flag lasts briefly and for a long time.
- Gain steps in each phase.
- A tone held through reset.

Each pattern separates a different exit path. The flag-absent and early-drop cases check the exact cycle of the reject pulse, and that cycle exposes any error in window length or prescaler phase. A pair of tones whose lengths differ by one clock straddles the duration limit, and this pair tells an off-by-one in the length count apart from a correct one. A reference model that counts elapsed clocks is compared with both outputs on every clock.

// File: rtl/alert_tone_pkg.sv
package alert_tone_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_OBSERVE = 2'd1,
        SEQ_LENGTH  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic ok;
        logic bad;
    } verdict_t;

    localparam verdict_t VERDICT_NONE = '{ok: 1'b0, bad: 1'b0};
    localparam verdict_t VERDICT_OK   = '{ok: 1'b1, bad: 1'b0};
    localparam verdict_t VERDICT_BAD  = '{ok: 1'b0, bad: 1'b1};

    // width of a counter that must hold values 0..v-1, at least one bit
    function automatic int unsigned cnt_width(int unsigned v);
        return (v < 2) ? 1 : $clog2(v);
    endfunction

    function automatic verdict_t length_verdict(logic below_limit);
        return below_limit ? VERDICT_OK : VERDICT_BAD;
    endfunction

endpackage

// File: rtl/alert_tick_gen.sv
module alert_tick_gen #(
    parameter int unsigned DIV = 1790
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic tick
);
    import alert_tone_pkg::*;

    localparam int unsigned W = cnt_width(DIV);
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt_q;

    assign tick = en && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/alert_window_timer.sv
module alert_window_timer #(
    parameter int unsigned TICKS = 116
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    output logic expired
);
    import alert_tone_pkg::*;

    localparam int unsigned W = cnt_width(TICKS);
    localparam logic [W-1:0] LAST = W'(TICKS - 1);

    logic [W-1:0] cnt_q;

    assign expired = tick && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (tick && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/alert_len_meter.sv
module alert_len_meter #(
    parameter int unsigned LIMIT = 45
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    input  logic level,
    output logic below
);
    import alert_tone_pkg::*;

    localparam int unsigned W = cnt_width(LIMIT + 1);
    localparam logic [W-1:0] CAP = W'(LIMIT);

    logic [W-1:0] cnt_q;

    assign below = (cnt_q < CAP);

    // saturating count of ticks with the level high
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (tick && level && below) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/alert_tone_qualifier.sv
module alert_tone_qualifier #(
    parameter int unsigned HALF_MS_DIV     = 1790,
    parameter int unsigned WINDOW_TICKS    = 116,
    parameter int unsigned LEN_LIMIT_TICKS = 45
) (
    input  logic clk,
    input  logic rst,
    input  logic tone_seen,
    input  logic pre_hit,
    input  logic gain_step,
    output logic alert_ok,
    output logic alert_bad
);
    import alert_tone_pkg::*;

    seq_state_e state_q, state_d;
    verdict_t   verdict_q, verdict_d;
    logic       tone_q;
    logic       tone_rise;
    logic       tick, win_done, len_below;
    logic       tick_clr, win_clr, len_clr, active;

    assign tone_rise = tone_seen && !tone_q;
    assign active    = (state_q != SEQ_IDLE);
    assign tick_clr  = !active || (state_d != state_q);
    assign win_clr   = (state_q != SEQ_OBSERVE);
    assign len_clr   = (state_q != SEQ_LENGTH);

    alert_tick_gen #(.DIV(HALF_MS_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .clr  (tick_clr),
        .en   (active),
        .tick (tick)
    );

    alert_window_timer #(.TICKS(WINDOW_TICKS)) u_window (
        .clk     (clk),
        .rst     (rst),
        .clr     (win_clr),
        .tick    (tick),
        .expired (win_done)
    );

    alert_len_meter #(.LIMIT(LEN_LIMIT_TICKS)) u_len (
        .clk   (clk),
        .rst   (rst),
        .clr   (len_clr),
        .tick  (tick),
        .level (pre_hit),
        .below (len_below)
    );

    always_comb begin
        state_d   = state_q;
        verdict_d = VERDICT_NONE;
        unique case (state_q)
            SEQ_IDLE: begin
                if (tone_rise) state_d = SEQ_OBSERVE;
            end
            SEQ_OBSERVE: begin
                if (gain_step) begin
                    state_d = SEQ_IDLE;
                end else if (!tone_seen) begin
                    verdict_d = VERDICT_BAD;
                    state_d   = SEQ_IDLE;
                end else if (win_done) begin
                    if (pre_hit) begin
                        state_d = SEQ_LENGTH;
                    end else begin
                        verdict_d = VERDICT_BAD;
                        state_d   = SEQ_IDLE;
                    end
                end
            end
            SEQ_LENGTH: begin
                if (gain_step) begin
                    state_d = SEQ_IDLE;
                end else if (!tone_seen) begin
                    verdict_d = length_verdict(len_below);
                    state_d   = SEQ_IDLE;
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SEQ_IDLE;
            verdict_q <= VERDICT_NONE;
            tone_q    <= 1'b1;   // a level already high at release is no rise
        end else begin
            state_q   <= state_d;
            verdict_q <= verdict_d;
            tone_q    <= tone_seen;
        end
    end

    assign alert_ok  = verdict_q.ok;
    assign alert_bad = verdict_q.bad;
endmodule

// File: rtl/alert_tone_qualifier_chk.sv
module alert_tone_qualifier_chk (
    input logic       clk,
    input logic       rst,
    input logic       tone_seen,
    input logic       gain_step,
    input logic       alert_ok,
    input logic       alert_bad,
    input logic [1:0] seq_state
);
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (seq_state == 2'd0) && !alert_ok && !alert_bad);

    a_r2_no_start_low: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 2'd0 && !tone_seen) |=> (seq_state == 2'd0));

    a_r3_pulse_from_active: assert property (@(posedge clk) disable iff (rst)
        (alert_ok || alert_bad) |-> ($past(seq_state) != 2'd0));

    a_r6_ok_after_fall: assert property (@(posedge clk) disable iff (rst)
        alert_ok |-> !$past(tone_seen));

    a_r8_gain_abort: assert property (@(posedge clk) disable iff (rst)
        (seq_state != 2'd0 && gain_step) |=> (seq_state == 2'd0) && !alert_ok && !alert_bad);

    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(alert_ok && alert_bad));

    a_r9_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (alert_ok || alert_bad) |=> !(alert_ok || alert_bad));
endmodule

bind alert_tone_qualifier alert_tone_qualifier_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tone_seen (tone_seen),
    .gain_step (gain_step),
    .alert_ok  (alert_ok),
    .alert_bad (alert_bad),
    .seq_state (state_q)
);

// File: tb/alert_tone_qualifier_bench.sv
module alert_tone_qualifier_bench;
    localparam int DIV = 4;
    localparam int WIN = 10;
    localparam int LIM = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tone_seen = 1'b0;
    logic pre_hit = 1'b0;
    logic gain_step = 1'b0;
    logic alert_ok, alert_bad;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ok_cnt = 0;
    int bad_cnt = 0;
    int last_pulse = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    alert_tone_qualifier #(
        .HALF_MS_DIV(DIV), .WINDOW_TICKS(WIN), .LEN_LIMIT_TICKS(LIM)
    ) u_alert_tone_qualifier (
        .clk(clk), .rst(rst), .tone_seen(tone_seen), .pre_hit(pre_hit),
        .gain_step(gain_step), .alert_ok(alert_ok), .alert_bad(alert_bad)
    );

    task automatic chk(input bit good, input string req, input int act, input int exp);
        checks++;
        if (!good) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // reference model: elapsed clocks per phase, phase 0 idle, 1 window, 2 length
    int  m_ph = 0;
    int  m_el = 0;
    int  m_hi = 0;
    bit  m_prev = 1'b1;
    bit  e_ok = 1'b0;
    bit  e_bad = 1'b0;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_ph = 0; m_prev = 1'b1; e_ok = 1'b0; e_bad = 1'b0;
        end else begin
            e_ok = 1'b0; e_bad = 1'b0;
            if (m_ph == 0) begin
                if (tone_seen && !m_prev) begin m_ph = 1; m_el = 0; end
            end else if (m_ph == 1) begin
                if (gain_step) m_ph = 0;
                else if (!tone_seen) begin e_bad = 1'b1; m_ph = 0; end
                else if (m_el == WIN * DIV - 1) begin
                    if (pre_hit) begin m_ph = 2; m_el = 0; m_hi = 0; end
                    else begin e_bad = 1'b1; m_ph = 0; end
                end else m_el++;
            end else begin
                if (gain_step) m_ph = 0;
                else if (!tone_seen) begin
                    if (m_hi < LIM) e_ok = 1'b1; else e_bad = 1'b1;
                    m_ph = 0;
                end else begin
                    if ((m_el % DIV) == DIV - 1 && pre_hit) m_hi++;
                    m_el++;
                end
            end
            m_prev = tone_seen;
        end
    end

    // per-cycle comparison and pulse bookkeeping
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(alert_ok === e_ok, "R6/R7 ok vs model", int'(alert_ok), int'(e_ok));
            chk(alert_bad === e_bad, "R4/R5 bad vs model", int'(alert_bad), int'(e_bad));
            chk(!(alert_ok && alert_bad), "R9 exclusive", int'(alert_ok && alert_bad), 0);
            if (alert_ok) ok_cnt++;
            if (alert_bad) bad_cnt++;
            if (alert_ok || alert_bad) last_pulse = cyc;
        end
    end

    task automatic run_tone(input int hold, input int pre_on, input int pre_off,
                            input int gain_at, output int n_ok, output int n_bad,
                            output int rel);
        int o0 = ok_cnt;
        int b0 = bad_cnt;
        int c0 = cyc;
        for (int i = 0; i < hold; i++) begin
            tone_seen = 1'b1;
            pre_hit   = (i >= pre_on) && (i < pre_off);
            gain_step = (i == gain_at);
            @(negedge clk);
        end
        tone_seen = 1'b0; pre_hit = 1'b0; gain_step = 1'b0;
        repeat (8) @(negedge clk);
        n_ok  = ok_cnt - o0;
        n_bad = bad_cnt - b0;
        rel   = last_pulse - c0;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n_ok, n_bad, rel;
        // R1: reset state, with the tone-like flag held high through reset
        tone_seen = 1'b1;
        repeat (3) @(negedge clk);
        chk(!alert_ok && !alert_bad, "R1 outputs in reset", int'(alert_ok | alert_bad), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!alert_ok && !alert_bad, "R1 outputs after reset", int'(alert_ok | alert_bad), 0);
        // R2: level held high from reset opens nothing
        run_tone(60, 0, 60, -1, n_ok, n_bad, rel);
        chk(n_ok + n_bad == 0, "R2 held level no candidate", n_ok + n_bad, 0);
        // R2: pre/gain activity while idle
        for (int i = 0; i < 12; i++) begin
            pre_hit = i[0]; gain_step = i[1];
            @(negedge clk);
        end
        pre_hit = 1'b0; gain_step = 1'b0;
        chk(ok_cnt + bad_cnt == 0, "R2 idle ignores pre/gain", ok_cnt + bad_cnt, 0);
        // R5: tone drops inside the window
        run_tone(20, 0, 20, -1, n_ok, n_bad, rel);
        chk(n_bad == 1 && n_ok == 0, "R5 early drop rejects", n_bad, 1);
        chk(rel == 21, "R5 reject cycle", rel, 21);
        // R4 and R3: pass flag absent at window end
        run_tone(64, 1000, 1000, -1, n_ok, n_bad, rel);
        chk(n_bad == 1 && n_ok == 0, "R4 absent flag rejects", n_bad, 1);
        chk(rel == WIN * DIV + 1, "R3 window length", rel, WIN * DIV + 1);
        // R6: brief pass flag accepted
        run_tone(64, 30, 50, -1, n_ok, n_bad, rel);
        chk(n_ok == 1 && n_bad == 0, "R6 short flag accepts", n_ok, 1);
        // R7: long pass flag rejected
        run_tone(100, 20, 100, -1, n_ok, n_bad, rel);
        chk(n_bad == 1 && n_ok == 0, "R7 long flag rejects", n_bad, 1);
        // R10: boundary, five ticks versus six
        run_tone(64, 0, 1000, -1, n_ok, n_bad, rel);
        chk(n_ok == 1 && n_bad == 0, "R10 limit-1 ticks accepts", n_ok, 1);
        run_tone(65, 0, 1000, -1, n_ok, n_bad, rel);
        chk(n_bad == 1 && n_ok == 0, "R10 limit ticks rejects", n_bad, 1);
        // R8: gain step in each phase
        run_tone(64, 0, 1000, 10, n_ok, n_bad, rel);
        chk(n_ok + n_bad == 0, "R8 gain in window aborts", n_ok + n_bad, 0);
        run_tone(64, 0, 1000, 50, n_ok, n_bad, rel);
        chk(n_ok + n_bad == 0, "R8 gain in length aborts", n_ok + n_bad, 0);
        // R8: a new rise after an abort works again
        run_tone(64, 30, 50, -1, n_ok, n_bad, rel);
        chk(n_ok == 1, "R8 fresh rise accepted", n_ok, 1);
        // R1: reset in mid-window with tone still high
        tone_seen = 1'b1; pre_hit = 1'b1;
        repeat (30) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        run_tone(70, 0, 70, -1, n_ok, n_bad, rel);
        chk(n_ok + n_bad == 0, "R1 reset drops candidate", n_ok + n_bad, 0);
        chk(!alert_ok && !alert_bad, "R9 outputs quiet at end", int'(alert_ok | alert_bad), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule